// File: doc/BRIEF.md
# Cell Balancing Selector and Timer

This block decides which cells of a series stack of up to `NCELL` cells are being bled for balancing, and keeps time on that activity. The host controls it in two ways. It can load an explicit cell mask, which is used exactly as written. It can instead write a signed millivolt level. The block then picks the cells whose measured voltage is above that level. The pick never includes two neighbouring cells and never exceeds a programmable count.

The selection is made once, in the cycle of the write, from the cell voltages present at that moment. It is held until the next write. Every write replaces the previous selection completely.

Two kinds of timing are reported, both advanced by a one-second tick input. A shared counter reports how many seconds balancing has been continuously active. A saturating counter per cell accumulates the total seconds that cell has been balanced since reset.

Top module: `cell_balance_ctrl`

## Requirements
- R1: After reset, the active mask, the continuous-seconds counter and every per-cell seconds counter are all zero.
- R2: A direct-mask write (`mask_wr_i` high) loads `mask_data_i` into the active mask unchanged, adjacent bits included. If a level write occurs in the same cycle, the direct-mask write wins.
- R3: A direct-mask write of zero turns off balancing on every cell.
- R4: A level write selects cells by scanning from cell 0 (bit 0) upward. A cell is selected only when its signed voltage is strictly greater than the signed level and the cell just below it was not selected. As a result, no two adjacent bits are ever set by a level write.
- R5: A level write selects at most `max_cells_i` cells; once that many are chosen, the scan stops. A value of zero selects none.
- R6: The selection is taken from the voltages present in the write cycle. Without a new write, the active mask holds even if the voltages change.
- R7: While the active mask is non-zero, each tick adds one to the continuous-seconds counter, which saturates at all ones.
- R8: At every clock edge where the active mask is zero, the continuous-seconds counter is cleared to zero.
- R9: On a tick, each cell whose bit is set in the active mask adds one to its own seconds counter. Counters of unselected cells, and all counters between ticks, stay unchanged.
- R10: Each per-cell seconds counter saturates at all ones.
- R11: The active mask takes its new value at the clock edge that samples the write strobe. Counters use the mask that was present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse marking one elapsed second |
| mask_wr_i | input | 1 | Direct-mask write strobe |
| mask_data_i | input | NCELL | Mask to apply on a direct write; bit i is cell i |
| lvl_wr_i | input | 1 | Level write strobe |
| lvl_mv_i | input | MV_W | Signed millivolt level for threshold selection |
| max_cells_i | input | clog2(NCELL+1) | Maximum number of cells a level write may pick |
| cell_mv_i | input | NCELL*MV_W | Signed cell voltages; cell i at bits [i*MV_W +: MV_W] |
| active_mask_o | output | NCELL | Cells currently balanced |
| run_secs_o | output | RUN_W | Seconds balancing has been continuously active |
| cell_secs_o | output | NCELL*CNT_W | Per-cell cumulative seconds; cell i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench keeps the default 10 cells and 16-bit voltages. It narrows the per-cell counters to 6 bits and the continuous counter to 5 bits. With these widths, both saturation points are reached within a few dozen ticks instead of years of seconds. The full 10-cell width still exercises the adjacency rule across every bit pair, and the count limit at 0, 2 and above the number of candidates. The level tests use negative levels to check the signed comparison.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MASK  = 2'd1,
    SRC_LEVEL = 2'd2
  } wr_src_e;
endpackage

// File: rtl/cbal_sat_counter.sv
module cbal_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= sat_step(q_o);
  end
endmodule

// File: rtl/cbal_select.sv
module cbal_select #(
  parameter int NCELL = 10,
  parameter int MV_W  = 16,
  localparam int MAX_W = $clog2(NCELL + 1)
) (
  input  logic [NCELL*MV_W-1:0] cell_mv_i,
  input  logic [MV_W-1:0]       lvl_mv_i,
  input  logic [MAX_W-1:0]      max_cells_i,
  output logic [NCELL-1:0]      sel_o
);
  function automatic logic above(input logic [MV_W-1:0] v, input logic [MV_W-1:0] lvl);
    return $signed(v) > $signed(lvl);
  endfunction

  logic [MAX_W-1:0] taken [NCELL+1];
  logic [NCELL:0]   prev_sel;

  assign taken[0]    = '0;
  assign prev_sel[0] = 1'b0;

  for (genvar i = 0; i < NCELL; i++) begin : g_chain
    logic cand;
    assign cand         = above(cell_mv_i[i*MV_W +: MV_W], lvl_mv_i);
    assign sel_o[i]     = cand && !prev_sel[i] && (taken[i] < max_cells_i);
    assign prev_sel[i+1] = sel_o[i];
    assign taken[i+1]   = taken[i] + {{(MAX_W-1){1'b0}}, sel_o[i]};
  end
endmodule

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl
  import cbal_pkg::*;
#(
  parameter int NCELL = 10,
  parameter int MV_W  = 16,
  parameter int CNT_W = 32,
  parameter int RUN_W = 16,
  localparam int MAX_W = $clog2(NCELL + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   mask_wr_i,
  input  logic [NCELL-1:0]       mask_data_i,
  input  logic                   lvl_wr_i,
  input  logic [MV_W-1:0]        lvl_mv_i,
  input  logic [MAX_W-1:0]       max_cells_i,
  input  logic [NCELL*MV_W-1:0]  cell_mv_i,
  output logic [NCELL-1:0]       active_mask_o,
  output logic [RUN_W-1:0]       run_secs_o,
  output logic [NCELL*CNT_W-1:0] cell_secs_o
);
  wr_src_e          wr_src;
  logic [NCELL-1:0] sel_mask;
  logic             mask_zero;
  logic             tick_active;

  always_comb begin
    if (mask_wr_i)     wr_src = SRC_MASK;
    else if (lvl_wr_i) wr_src = SRC_LEVEL;
    else               wr_src = SRC_NONE;
  end

  cbal_select #(.NCELL(NCELL), .MV_W(MV_W)) u_select (
    .cell_mv_i   (cell_mv_i),
    .lvl_mv_i    (lvl_mv_i),
    .max_cells_i (max_cells_i),
    .sel_o       (sel_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_mask_o <= '0;
    else begin
      case (wr_src)
        SRC_MASK:  active_mask_o <= mask_data_i;
        SRC_LEVEL: active_mask_o <= sel_mask;
        default:   active_mask_o <= active_mask_o;
      endcase
    end
  end

  assign mask_zero   = (active_mask_o == '0);
  assign tick_active = tick_i && !mask_zero;

  cbal_sat_counter #(.W(RUN_W)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (mask_zero),
    .inc_i (tick_active),
    .q_o   (run_secs_o)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    cbal_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (1'b0),
      .inc_i (tick_i && active_mask_o[i]),
      .q_o   (cell_secs_o[i*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/cbal_checker.sv
module cbal_checker #(
  parameter int NCELL = 10,
  parameter int CNT_W = 32,
  parameter int RUN_W = 16,
  parameter int MAX_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tick_i,
  input logic                   mask_wr_i,
  input logic [NCELL-1:0]       mask_data_i,
  input logic                   lvl_wr_i,
  input logic [MAX_W-1:0]       max_cells_i,
  input logic [NCELL-1:0]       active_mask_o,
  input logic [RUN_W-1:0]       run_secs_o,
  input logic [NCELL*CNT_W-1:0] cell_secs_o
);
  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> active_mask_o == $past(mask_data_i)); // R2
  AST_LEVEL_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_wr_i && !mask_wr_i) |=> (active_mask_o & (active_mask_o >> 1)) == '0); // R4
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_wr_i && !mask_wr_i) |=> $countones(active_mask_o) <= int'($past(max_cells_i))); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_wr_i && !mask_wr_i) |=> $stable(active_mask_o)); // R6
  AST_RUN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_secs_o == {RUN_W{1'b1}} && active_mask_o != '0) |=> run_secs_o == {RUN_W{1'b1}}); // R7
  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mask_o == '0) |=> run_secs_o == '0); // R8

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    AST_CELL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && active_mask_o[i]) |=> $stable(cell_secs_o[i*CNT_W +: CNT_W])); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_secs_o[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}) |=> cell_secs_o[i*CNT_W +: CNT_W] == {CNT_W{1'b1}}); // R10
  end
endmodule

bind cell_balance_ctrl cbal_checker #(
  .NCELL(NCELL), .CNT_W(CNT_W), .RUN_W(RUN_W), .MAX_W(MAX_W)
) u_cbal_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .mask_wr_i     (mask_wr_i),
  .mask_data_i   (mask_data_i),
  .lvl_wr_i      (lvl_wr_i),
  .max_cells_i   (max_cells_i),
  .active_mask_o (active_mask_o),
  .run_secs_o    (run_secs_o),
  .cell_secs_o   (cell_secs_o)
);

// File: tb/tb_cell_balance_ctrl.sv
`timescale 1ns/1ps
module tb_cell_balance_ctrl;
  localparam int NCELL = 10;
  localparam int MV_W  = 16;
  localparam int CNT_W = 6;
  localparam int RUN_W = 5;
  localparam int MAX_W = $clog2(NCELL + 1);
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int RMAX  = (1 << RUN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mask_wr = 1'b0;
  logic [NCELL-1:0] mask_data = '0;
  logic lvl_wr = 1'b0;
  logic signed [MV_W-1:0] lvl = '0;
  logic [MAX_W-1:0] maxc = '0;
  logic signed [MV_W-1:0] mv [NCELL];
  logic [NCELL*MV_W-1:0] mv_flat;
  logic [NCELL-1:0] act_mask;
  logic [RUN_W-1:0] run_secs;
  logic [NCELL*CNT_W-1:0] cell_secs;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NCELL-1:0] m_mask;
  int m_run;
  int m_cell [NCELL];

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NCELL; i++) mv_flat[i*MV_W +: MV_W] = mv[i];

  cell_balance_ctrl #(.NCELL(NCELL), .MV_W(MV_W), .CNT_W(CNT_W), .RUN_W(RUN_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .lvl_wr_i(lvl_wr), .lvl_mv_i(lvl), .max_cells_i(maxc), .cell_mv_i(mv_flat),
    .active_mask_o(act_mask), .run_secs_o(run_secs), .cell_secs_o(cell_secs)
  );

  function automatic logic [NCELL-1:0] ref_pick();
    logic [NCELL-1:0] r = '0;
    int n = 0;
    for (int i = 0; i < NCELL; i++) begin
      if (n >= int'(maxc)) break;
      if (int'(mv[i]) > int'(lvl) && (i == 0 || !r[i-1])) begin
        r[i] = 1'b1;
        n++;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_run = 0;
      for (int i = 0; i < NCELL; i++) m_cell[i] = 0;
    end else begin
      if (m_mask == '0) m_run = 0;
      else if (tick && m_run < RMAX) m_run++;
      for (int i = 0; i < NCELL; i++)
        if (tick && m_mask[i] && m_cell[i] < CMAX) m_cell[i]++;
      if (mask_wr) m_mask = mask_data;
      else if (lvl_wr) m_mask = ref_pick();
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R4/R5 model mask", longint'(act_mask), longint'(m_mask));
      chk("R7/R8 model run", longint'(run_secs), longint'(m_run));
      for (int i = 0; i < NCELL; i++)
        chk("R9/R10 model cell", longint'(cell_secs[i*CNT_W +: CNT_W]), longint'(m_cell[i]));
    end
  end

  task automatic wr_mask(input logic [NCELL-1:0] m);
    @(negedge clk); mask_wr = 1'b1; mask_data = m;
    @(negedge clk); mask_wr = 1'b0; #1;
  endtask

  task automatic wr_lvl(input int l, input int mx);
    @(negedge clk); lvl_wr = 1'b1; lvl = MV_W'(l); maxc = MAX_W'(mx);
    @(negedge clk); lvl_wr = 1'b0; #1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCELL; i++) mv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mask", longint'(act_mask), 0);
    chk("R1 run", longint'(run_secs), 0);
    for (int i = 0; i < NCELL; i++) chk("R1 cell", longint'(cell_secs[i*CNT_W +: CNT_W]), 0);

    // R2 adjacent bits kept, R11 visible after one edge
    wr_mask(10'h3FF);
    chk("R2 R11 direct all", longint'(act_mask), 10'h3FF);
    ticks(3);
    chk("R7 run count", longint'(run_secs), 3);
    chk("R9 cell count", longint'(cell_secs[0 +: CNT_W]), 3);
    ticks(70);
    chk("R7 run saturate", longint'(run_secs), RMAX);
    chk("R10 cell saturate", longint'(cell_secs[9*CNT_W +: CNT_W]), CMAX);

    // R3 write zero, R8 clear
    wr_mask('0);
    chk("R3 mask off", longint'(act_mask), 0);
    @(negedge clk); #1;
    chk("R8 run cleared", longint'(run_secs), 0);
    chk("R10 cell kept", longint'(cell_secs[4*CNT_W +: CNT_W]), CMAX);

    // R4 threshold, all cells above
    for (int i = 0; i < NCELL; i++) mv[i] = 16'sd4000;
    wr_lvl(3000, 10);
    chk("R4 no adjacent", longint'(act_mask), 10'h155);
    wr_lvl(3000, 2);
    chk("R5 max two", longint'(act_mask), 10'h005);
    wr_lvl(3000, 0);
    chk("R5 max zero", longint'(act_mask), 0);

    // R4 mixed pattern and equality is not above
    mv[0] = 16'sd3500; mv[1] = 16'sd3500; mv[2] = 16'sd3000; mv[3] = 16'sd3100;
    mv[4] = 16'sd3100; mv[5] = 16'sd3100;
    for (int i = 6; i < NCELL; i++) mv[i] = 16'sd0;
    wr_lvl(3000, 10);
    chk("R4 mixed", longint'(act_mask), 10'h029);

    // R4 signed level
    for (int i = 0; i < NCELL; i++) mv[i] = 16'sd0;
    mv[1] = -16'sd500;
    wr_lvl(-1, 10);
    chk("R4 signed", longint'(act_mask), 10'h155);

    // R6 voltages change without write
    for (int i = 0; i < NCELL; i++) mv[i] = -16'sd900;
    repeat (3) @(negedge clk); #1;
    chk("R6 hold", longint'(act_mask), 10'h155);

    // R2 priority of direct write
    @(negedge clk); mask_wr = 1'b1; mask_data = 10'h300; lvl_wr = 1'b1; lvl = -16'sd2000;
    @(negedge clk); mask_wr = 1'b0; lvl_wr = 1'b0; #1;
    chk("R2 priority", longint'(act_mask), 10'h300);

    // random phase, model compared on every clock
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) == 0);
      mask_wr = ($urandom_range(0, 15) == 0);
      mask_data = NCELL'($urandom);
      lvl_wr = ($urandom_range(0, 7) == 0);
      lvl = MV_W'($urandom_range(0, 2000)) - 16'sd1000;
      maxc = MAX_W'($urandom_range(0, NCELL + 1));
      for (int i = 0; i < NCELL; i++) mv[i] = MV_W'($urandom_range(0, 2000)) - 16'sd1000;
    end
    @(negedge clk);
    tick = 1'b0; mask_wr = 1'b0; lvl_wr = 1'b0;
    @(negedge clk); #1;
    finish_run();
  end
endmodule